// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block sits behind the asynchronous parallel bus of a flash memory and turns host writes into device actions. Each write cycle offers a command byte on the low half of the data bus. The block follows one-cycle commands and two-cycle setup/confirm sequences. It selects what a host read returns: array data, a status register, an identifier word or a query word. It also launches program and erase jobs on a write engine.

The write engine is a busy counter that stands in for the real cell algorithms. Program jobs last 16 clock cycles and erase jobs last 64. While a job runs, a host can suspend it, look at status or array data, and resume it. Once the engine is busy, the block takes only a small subset of commands until the job finishes.

There are two memory partitions, and the most significant address bit picks one. Each partition has its own status byte. The address of a status request or of a job tells the block which partition's status to return. The address and data word of the running job appear on the job outputs, where a cell-array model can pick them up.

Top module: `flash_cmd_if`

## Requirements
- R1: After the synchronous active-low reset, the block is in array mode and `dq_out` equals `array_rdata`. Both status bytes read 0x80 (ready, no error bits), and any running job is cancelled. `dq_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1.
- R2: A bus write is taken only when `ce_n`, `adv_n` and `we_n` are all 0 and `oe_n` is 1. One stretch of such a cycle yields exactly one command, however many clocks it lasts. The command byte is `dq_in[7:0]`.
- R3: 70h selects status mode, and reads then return {8'h00, status byte}. 90h selects identifier mode, which returns 16'h00A5 at even addresses and 16'h5A01 at odd ones. 98h selects query mode, which returns 16'h0051. FFh selects array mode. An undefined byte changes nothing.
- R4: A program job starts when 40h, 10h or C0h is followed by one more write of any value. The setup write alone starts nothing. The job keeps status bit 7 (ready) at 0 for 16 clock cycles, and `job_addr`/`job_data` hold that second write's address and data. After the job is accepted, reads return status until FFh is written.
- R5: An erase job starts when 20h is followed by D0h. It keeps status bit 7 at 0 for 64 clock cycles.
- R6: If 20h is followed by any byte other than D0h, no job starts and status bit 7 stays 1. Status bits 5 and 4 are set in the partition given by that second write's address, and the block goes to status mode.
- R7: The partition is `addr[ADDR_W-1]`. A status read returns the byte of the partition named by the latest 70h write or job address. Error bits and job bits appear only in their own partition. The other partition shows 0x80 while a job runs.
- R8: 50h, written while no job is running, clears status bits 1 to 5 in both partitions.
- R9: While a job is running and not suspended, only 70h and B0h have any effect. Any other write, FFh included, leaves the read mode and the job as they were.
- R10: B0h during a running job freezes its count, sets status bit 7, and sets bit 6 for an erase job or bit 2 for a program job. While the job is suspended, 70h, FFh, 90h and 98h are taken. D0h clears the suspend, enters status mode and resumes the count where it stopped.
- R11: 60h uses up the next write, whatever its value, and then returns to array mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| adv_n | input | 1 | Address valid, active low |
| addr | input | ADDR_W | Word address; the top bit selects the partition |
| dq_in | input | DQ_W | Data written by the host; the low byte carries commands |
| array_rdata | input | DQ_W | Word read from the cell array at `addr` |
| dq_out | output | DQ_W | Read data for the current read mode |
| dq_oe | output | 1 | High while the host is reading |
| job_addr | output | ADDR_W | Address of the latest accepted job |
| job_data | output | DQ_W | Data word of the latest accepted job |

## Verification
The single-cycle commands are run from a table. It pairs each mode byte, and one undefined byte, with reads at even, odd, low and high-partition addresses, so the identifier words can be told apart from query words and array words. Write strobes are tried in four forms: a strobe missing one qualifier, a strobe held for several clocks, a setup byte followed by a confirm, and a setup byte followed by a wrong byte. These show whether the block counts commands per strobe and whether it waits for a full sequence. Program and erase jobs are read back just before and just after their cycle counts end. They are also suspended for far longer than their remaining count and then resumed. This shows whether the count really stops and whether only the selected partition's status changes.

// File: rtl/flash_cmd_pkg.sv
// Shared types and constants for the flash command interface.
// Assumes command bytes arrive on the low byte of the data bus.
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_IDENT  = 2'd2,
        RD_QUERY  = 2'd3
    } rd_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PGM  = 2'd1,
        SEQ_ERS  = 2'd2,
        SEQ_CFG  = 2'd3
    } seq_e;

    typedef enum logic {
        OP_PGM = 1'b0,
        OP_ERS = 1'b1
    } op_e;

    localparam logic [7:0] CMD_PGM     = 8'h40;
    localparam logic [7:0] CMD_PGM_ALT = 8'h10;
    localparam logic [7:0] CMD_ERS     = 8'h20;
    localparam logic [7:0] CMD_CLR     = 8'h50;
    localparam logic [7:0] CMD_CFG     = 8'h60;
    localparam logic [7:0] CMD_STAT    = 8'h70;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_SUSP    = 8'hB0;
    localparam logic [7:0] CMD_PROT    = 8'hC0;
    localparam logic [7:0] CMD_CONF    = 8'hD0;
    localparam logic [7:0] CMD_ARRAY   = 8'hFF;

    localparam int N_PART = 2;

endpackage

// File: rtl/flash_bus_sense.sv
// Turns the asynchronous bus strobes into one write event per strobe.
// Assumes the strobes are already stable in the clk domain.
module flash_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic adv_n,
    output logic wr_evt
);

    logic wr_now;
    logic wr_prev_q;

    // A write cycle is qualified by every control line.
    assign wr_now = !ce_n && !adv_n && !we_n && oe_n;

    // Remember the previous qualification so that only its leading edge counts.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_prev_q <= 1'b0;
        else        wr_prev_q <= wr_now;
    end

    assign wr_evt = wr_now && !wr_prev_q;

    AST_ONE_EVENT_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt); // R2

endmodule

// File: rtl/flash_cmd_decode.sv
// Command sequencer: tracks setup/confirm pairs, the read mode and the
// partition whose status is shown. Emits one-cycle requests to the engine
// and the status bank. Assumes wr_evt is one cycle per host write.
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_evt,
    input  logic [7:0] wr_byte,
    input  logic     wr_part,
    input  logic     eng_busy,
    input  logic     eng_susp,
    output rd_mode_e rd_mode,
    output logic     stat_part,
    output logic     start_op,
    output op_e      start_kind,
    output logic     req_susp,
    output logic     req_resume,
    output logic     clr_err,
    output logic     seq_err
);

    seq_e     seq_q, seq_d;
    rd_mode_e mode_q, mode_d;
    logic     spart_q, spart_d;

    // Read-mode bytes that are valid both when idle and when suspended.
    function automatic rd_mode_e mode_for(input logic [7:0] b, input rd_mode_e cur);
        rd_mode_e m;
        m = cur;
        if (b == CMD_ARRAY)      m = RD_ARRAY;
        else if (b == CMD_IDENT) m = RD_IDENT;
        else if (b == CMD_QUERY) m = RD_QUERY;
        return m;
    endfunction

    // Next-state and request decode for one host write.
    always_comb begin
        seq_d      = seq_q;
        mode_d     = mode_q;
        spart_d    = spart_q;
        start_op   = 1'b0;
        start_kind = OP_PGM;
        req_susp   = 1'b0;
        req_resume = 1'b0;
        clr_err    = 1'b0;
        seq_err    = 1'b0;
        if (wr_evt) begin
            unique case (seq_q)
                SEQ_PGM: begin
                    start_op = 1'b1;
                    mode_d   = RD_STATUS;
                    spart_d  = wr_part;
                    seq_d    = SEQ_IDLE;
                end
                SEQ_ERS: begin
                    if (wr_byte == CMD_CONF) begin
                        start_op   = 1'b1;
                        start_kind = OP_ERS;
                    end else begin
                        seq_err = 1'b1;
                    end
                    mode_d  = RD_STATUS;
                    spart_d = wr_part;
                    seq_d   = SEQ_IDLE;
                end
                SEQ_CFG: begin
                    mode_d = RD_ARRAY;
                    seq_d  = SEQ_IDLE;
                end
                default: begin
                    if (wr_byte == CMD_STAT) begin
                        mode_d  = RD_STATUS;
                        spart_d = wr_part;
                    end else if (eng_busy && !eng_susp) begin
                        if (wr_byte == CMD_SUSP) begin
                            req_susp = 1'b1;
                            mode_d   = RD_STATUS;
                        end
                    end else if (eng_busy) begin
                        if (wr_byte == CMD_CONF) begin
                            req_resume = 1'b1;
                            mode_d     = RD_STATUS;
                        end else begin
                            mode_d = mode_for(wr_byte, mode_q);
                        end
                    end else begin
                        unique case (wr_byte)
                            CMD_PGM, CMD_PGM_ALT, CMD_PROT: begin
                                seq_d  = SEQ_PGM;
                                mode_d = RD_STATUS;
                            end
                            CMD_ERS: begin
                                seq_d  = SEQ_ERS;
                                mode_d = RD_STATUS;
                            end
                            CMD_CFG: seq_d   = SEQ_CFG;
                            CMD_CLR: clr_err = 1'b1;
                            default: mode_d  = mode_for(wr_byte, mode_q);
                        endcase
                    end
                end
            endcase
        end
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q   <= SEQ_IDLE;
            mode_q  <= RD_ARRAY;
            spart_q <= 1'b0;
        end else begin
            seq_q   <= seq_d;
            mode_q  <= mode_d;
            spart_q <= spart_d;
        end
    end

    assign rd_mode   = mode_q;
    assign stat_part = spart_q;

    AST_BAD_CONFIRM_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && seq_q == SEQ_ERS && wr_byte != CMD_CONF)
            |=> (mode_q == RD_STATUS && seq_q == SEQ_IDLE)); // R6
    AST_CFG_RETURNS_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && seq_q == SEQ_CFG) |=> (mode_q == RD_ARRAY)); // R11
    AST_NO_SETUP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> (seq_q == SEQ_IDLE)); // R9

endmodule

// File: rtl/flash_wr_engine.sv
// Stand-in write engine: a busy counter sized per job kind, with suspend
// and resume. Latches the job address and data when a job starts.
// Assumes start_op arrives only while the engine is idle.
module flash_wr_engine
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DQ_W    = 16,
    parameter int PGM_CYC = 16,
    parameter int ERS_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_op,
    input  op_e               start_kind,
    input  logic              req_susp,
    input  logic              req_resume,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DQ_W-1:0]   wr_data,
    output logic              busy,
    output logic              susp,
    output op_e               kind,
    output logic              part,
    output logic [ADDR_W-1:0] job_addr,
    output logic [DQ_W-1:0]   job_data
);

    localparam int MAX_CYC = (ERS_CYC > PGM_CYC) ? ERS_CYC : PGM_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PGM_LEN = CNT_W'(PGM_CYC);
    localparam logic [CNT_W-1:0] ERS_LEN = CNT_W'(ERS_CYC);
    localparam logic [CNT_W-1:0] MAX_LEN = CNT_W'(MAX_CYC);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q, susp_q;
    op_e               kind_q;
    logic [ADDR_W-1:0] jaddr_q;
    logic [DQ_W-1:0]   jdata_q;

    // Job control: load on start, freeze on suspend, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            susp_q  <= 1'b0;
            kind_q  <= OP_PGM;
            cnt_q   <= '0;
            jaddr_q <= '0;
            jdata_q <= '0;
        end else if (start_op && !busy_q) begin
            busy_q  <= 1'b1;
            susp_q  <= 1'b0;
            kind_q  <= start_kind;
            cnt_q   <= (start_kind == OP_ERS) ? ERS_LEN : PGM_LEN;
            jaddr_q <= wr_addr;
            jdata_q <= wr_data;
        end else if (busy_q) begin
            if (req_susp) begin
                susp_q <= 1'b1;
            end else if (req_resume) begin
                susp_q <= 1'b0;
            end else if (!susp_q) begin
                if (cnt_q == ONE) busy_q <= 1'b0;
                else              cnt_q  <= cnt_q - ONE;
            end
        end
    end

    assign busy     = busy_q;
    assign susp     = susp_q;
    assign kind     = kind_q;
    assign part     = jaddr_q[ADDR_W-1];
    assign job_addr = jaddr_q;
    assign job_data = jdata_q;

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_op |-> !busy_q); // R9
    AST_SUSPEND_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && susp_q) |=> $stable(cnt_q)); // R10
    AST_FINISH_NOT_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> !$past(susp_q)); // R4
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q != '0 && cnt_q <= MAX_LEN)); // R5

endmodule

// File: rtl/flash_status_bank.sv
// One status byte per partition. Error bits are stored; ready and suspend
// bits come from the engine and show only in the job's partition.
// Layout: 7 ready, 6 erase suspended, 5 erase error, 4 program error,
// 3 supply error, 2 program suspended, 1 protect error, 0 reserved.
module flash_status_bank
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seq_err,
    input  logic       err_part,
    input  logic       clr_err,
    input  logic       eng_busy,
    input  logic       eng_susp,
    input  op_e        eng_kind,
    input  logic       eng_part,
    input  logic       rd_part,
    output logic [7:0] sr_out
);

    logic [7:0] sr_p [N_PART];

    for (genvar p = 0; p < N_PART; p++) begin : g_part
        logic [3:0] err_q;   // bits 5,4,3,1 of the status byte
        logic       tgt;

        // Stored error bits: clear on request, set on a bad erase confirm.
        always_ff @(posedge clk) begin
            if (!rst_n)                               err_q <= '0;
            else if (clr_err)                         err_q <= '0;
            else if (seq_err && (err_part == p[0]))   err_q[3:2] <= 2'b11;
        end

        assign tgt = eng_busy && (eng_part == p[0]);
        assign sr_p[p] = {!tgt || eng_susp,
                          tgt && eng_susp && (eng_kind == OP_ERS),
                          err_q[3], err_q[2], err_q[1],
                          tgt && eng_susp && (eng_kind == OP_PGM),
                          err_q[0], 1'b0};

        AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            clr_err |=> (err_q == 4'b0000)); // R8
        AST_BAD_CONFIRM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            (seq_err && err_part == p[0]) |=> (err_q[3:2] == 2'b11)); // R6
    end

    assign sr_out = sr_p[rd_part];

endmodule

// File: rtl/flash_rd_mux.sv
// Selects the read word for the current read mode. Combinational.
module flash_rd_mux
    import flash_cmd_pkg::*;
#(
    parameter int          DQ_W     = 16,
    parameter logic [15:0] ID_EVEN  = 16'h00A5,
    parameter logic [15:0] ID_ODD   = 16'h5A01,
    parameter logic [15:0] QRY_WORD = 16'h0051
) (
    input  rd_mode_e        rd_mode,
    input  logic            addr_lsb,
    input  logic [7:0]      sr,
    input  logic [DQ_W-1:0] array_rdata,
    output logic [DQ_W-1:0] dq
);

    // Word select by read mode.
    always_comb begin
        unique case (rd_mode)
            RD_STATUS: dq = {{(DQ_W-8){1'b0}}, sr};
            RD_IDENT:  dq = addr_lsb ? DQ_W'(ID_ODD) : DQ_W'(ID_EVEN);
            RD_QUERY:  dq = DQ_W'(QRY_WORD);
            default:   dq = array_rdata;
        endcase
    end

endmodule

// File: rtl/flash_cmd_if.sv
// Top of the flash command interface: bus sensing, command sequencing,
// write engine, per-partition status and read selection.
// Assumes bus strobes are synchronous to clk; the reset is synchronous.
module flash_cmd_if
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DQ_W    = 16,
    parameter int PGM_CYC = 16,
    parameter int ERS_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    input  logic [DQ_W-1:0]   array_rdata,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic [ADDR_W-1:0] job_addr,
    output logic [DQ_W-1:0]   job_data
);

    logic     wr_evt;
    rd_mode_e rd_mode;
    logic     stat_part, start_op, req_susp, req_resume, clr_err, seq_err;
    op_e      start_kind, eng_kind;
    logic     eng_busy, eng_susp, eng_part;
    logic [7:0] sr;
    logic     wr_part;

    assign wr_part = addr[ADDR_W-1];

    flash_bus_sense u_sense (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .adv_n  (adv_n),
        .wr_evt (wr_evt)
    );

    flash_cmd_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_evt     (wr_evt),
        .wr_byte    (dq_in[7:0]),
        .wr_part    (wr_part),
        .eng_busy   (eng_busy),
        .eng_susp   (eng_susp),
        .rd_mode    (rd_mode),
        .stat_part  (stat_part),
        .start_op   (start_op),
        .start_kind (start_kind),
        .req_susp   (req_susp),
        .req_resume (req_resume),
        .clr_err    (clr_err),
        .seq_err    (seq_err)
    );

    flash_wr_engine #(
        .ADDR_W  (ADDR_W),
        .DQ_W    (DQ_W),
        .PGM_CYC (PGM_CYC),
        .ERS_CYC (ERS_CYC)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_op   (start_op),
        .start_kind (start_kind),
        .req_susp   (req_susp),
        .req_resume (req_resume),
        .wr_addr    (addr),
        .wr_data    (dq_in),
        .busy       (eng_busy),
        .susp       (eng_susp),
        .kind       (eng_kind),
        .part       (eng_part),
        .job_addr   (job_addr),
        .job_data   (job_data)
    );

    flash_status_bank u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .seq_err  (seq_err),
        .err_part (wr_part),
        .clr_err  (clr_err),
        .eng_busy (eng_busy),
        .eng_susp (eng_susp),
        .eng_kind (eng_kind),
        .eng_part (eng_part),
        .rd_part  (stat_part),
        .sr_out   (sr)
    );

    flash_rd_mux #(
        .DQ_W (DQ_W)
    ) u_rdmux (
        .rd_mode     (rd_mode),
        .addr_lsb    (addr[0]),
        .sr          (sr),
        .array_rdata (array_rdata),
        .dq          (dq_out)
    );

    assign dq_oe = !ce_n && !oe_n && we_n;

    AST_JOB_SHOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_op && !eng_busy) |=> (eng_busy && !eng_susp)); // R4
    AST_IDLE_PART_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == RD_STATUS && eng_part != stat_part) |-> dq_out[7]); // R7

endmodule

// File: tb/tb_flash_cmd_if.sv
module tb_flash_cmd_if;

    localparam int ADDR_W = 12;
    localparam int DQ_W   = 16;
    localparam int PGM    = 16;
    localparam int ERS    = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, adv_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DQ_W-1:0]   dq_in = '0;
    logic [DQ_W-1:0]   array_rdata;
    logic [DQ_W-1:0]   dq_out;
    logic              dq_oe;
    logic [ADDR_W-1:0] job_addr;
    logic [DQ_W-1:0]   job_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    // Array model: each word shows A in its top nibble and its address below.
    assign array_rdata = {4'hA, addr};

    flash_cmd_if #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .PGM_CYC(PGM), .ERS_CYC(ERS)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .adv_n(adv_n), .addr(addr), .dq_in(dq_in), .array_rdata(array_rdata),
        .dq_out(dq_out), .dq_oe(dq_oe), .job_addr(job_addr), .job_data(job_data)
    );

    // Vector: write address, command byte, read address, expected read word.
    localparam logic [47:0] VECS [9] = '{
        48'h000_90_000_00A5,   // R3 identifier even
        48'h000_90_001_5A01,   // R3 identifier odd
        48'h000_98_010_0051,   // R3 query
        48'h000_70_000_0080,   // R3 status partition 0
        48'h800_70_000_0080,   // R3 status partition 1
        48'h000_FF_123_A123,   // R3 array
        48'h000_98_7FF_0051,   // R3 query, other address
        48'h000_FF_800_A800,   // R3 array, upper partition
        48'h000_77_004_A004    // R3 undefined byte: stays array
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    // Write strobe with selectable qualifiers, held for 'hold' clocks.
    task automatic bus_write_ctl(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                                 input logic ce, input logic adv, input logic oe, input int hold);
        addr = a; dq_in = d; ce_n = ce; adv_n = adv; oe_n = oe; we_n = 1'b0;
        for (int i = 0; i < hold; i++) @(posedge clk);
        @(negedge clk);
        ce_n = 1'b1; adv_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        bus_write_ctl(a, d, 1'b0, 1'b0, 1'b1, 1);
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [15:0] d, output logic oe);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        d = dq_out; oe = dq_oe;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic read_check(input string req, input logic [ADDR_W-1:0] a, input logic [15:0] exp);
        logic [15:0] d;
        logic o;
        bus_read(a, d, o);
        check(req, d, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic o;
        @(negedge clk);
        do_reset();

        // R1: reset state and output enable.
        bus_read(12'h005, d, o);
        check("R1 array after reset", d, 16'hA005);
        check("R1 dq_oe reading", {15'b0, o}, 16'h0001);
        #1; check("R1 dq_oe idle", {15'b0, dq_oe}, 16'h0000);

        // R3: table of single-cycle read-mode commands.
        for (int v = 0; v < 9; v++) begin
            bus_write(VECS[v][47:36], {8'h00, VECS[v][35:28]});
            read_check($sformatf("R3 vector %0d", v), VECS[v][27:16], VECS[v][15:0]);
        end

        // R2: strobes missing a qualifier are not commands.
        bus_write_ctl(12'h000, 16'h0070, 1'b0, 1'b0, 1'b0, 1);
        read_check("R2 oe_n low ignored", 12'h005, 16'hA005);
        bus_write_ctl(12'h000, 16'h0070, 1'b0, 1'b1, 1'b1, 1);
        read_check("R2 adv_n high ignored", 12'h005, 16'hA005);
        bus_write_ctl(12'h000, 16'h0070, 1'b1, 1'b0, 1'b1, 1);
        read_check("R2 ce_n high ignored", 12'h005, 16'hA005);
        bus_write(12'h000, 16'hAB70);
        read_check("R2 low byte is the command", 12'h000, 16'h0080);
        bus_write(12'h000, 16'h00FF);

        // R2/R4: a held setup strobe counts once; then program.
        bus_write_ctl(12'h000, 16'h0040, 1'b0, 1'b0, 1'b1, 3);
        read_check("R2 held strobe single command", 12'h000, 16'h0080);
        bus_write(12'h004, 16'h1234);
        read_check("R4 program busy", 12'h000, 16'h0000);
        check("R4 job_data", job_data, 16'h1234);
        check("R4 job_addr", {4'h0, job_addr}, 16'h0004);
        bus_write(12'h000, 16'h00FF);
        read_check("R9 FFh ignored while busy", 12'h000, 16'h0000);
        wait_cyc(PGM - 5);
        read_check("R4 still busy near end", 12'h000, 16'h0000);
        wait_cyc(2);
        read_check("R4 ready after 16 cycles", 12'h000, 16'h0080);
        bus_write(12'h000, 16'h00FF);
        read_check("R4 array after FFh", 12'h004, 16'hA004);

        // R4: alternate program byte and protection program byte.
        bus_write(12'h000, 16'h0010);
        bus_write(12'h002, 16'h0F0F);
        read_check("R4 alt program busy", 12'h000, 16'h0000);
        wait_cyc(PGM + 2);
        bus_write(12'h000, 16'h00C0);
        bus_write(12'h003, 16'h5555);
        read_check("R4 protection program busy", 12'h000, 16'h0000);
        wait_cyc(PGM + 2);
        read_check("R4 protection program done", 12'h000, 16'h0080);

        // R5: erase timing in partition 0.
        bus_write(12'h000, 16'h0020);
        read_check("R5 setup alone starts nothing", 12'h000, 16'h0080);
        bus_write(12'h010, 16'h00D0);
        wait_cyc(ERS - 3);
        read_check("R5 erase busy near end", 12'h000, 16'h0000);
        wait_cyc(2);
        read_check("R5 erase ready after 64", 12'h000, 16'h0080);

        // R7/R10: erase in partition 1, suspend, resume.
        bus_write(12'h800, 16'h0020);
        bus_write(12'h800, 16'h00D0);
        read_check("R7 job partition busy", 12'h000, 16'h0000);
        bus_write(12'h000, 16'h0070);
        read_check("R7 other partition ready", 12'h000, 16'h0080);
        bus_write(12'h800, 16'h0070);
        bus_write(12'h800, 16'h00B0);
        read_check("R10 erase suspended", 12'h000, 16'h00C0);
        wait_cyc(100);
        read_check("R10 suspend holds", 12'h000, 16'h00C0);
        bus_write(12'h000, 16'h00FF);
        read_check("R10 array while suspended", 12'h123, 16'hA123);
        bus_write(12'h800, 16'h0070);
        read_check("R10 status while suspended", 12'h000, 16'h00C0);
        bus_write(12'h800, 16'h00D0);
        read_check("R10 resumed busy", 12'h000, 16'h0000);
        wait_cyc(20);
        read_check("R10 count was frozen", 12'h000, 16'h0000);
        wait_cyc(60);
        read_check("R10 resumed job done", 12'h000, 16'h0080);

        // R10: program suspend shows bit 2.
        bus_write(12'h000, 16'h0040);
        bus_write(12'h000, 16'h00AA);
        bus_write(12'h000, 16'h00B0);
        read_check("R10 program suspended", 12'h000, 16'h0084);
        bus_write(12'h000, 16'h00D0);
        wait_cyc(PGM + 4);
        read_check("R10 program resumed done", 12'h000, 16'h0080);

        // R6/R7/R8: bad erase confirm, per partition, then clear.
        bus_write(12'h000, 16'h0020);
        bus_write(12'h000, 16'h0033);
        read_check("R6 bad confirm flags", 12'h000, 16'h00B0);
        bus_write(12'h800, 16'h0070);
        read_check("R7 errors stay in partition 0", 12'h000, 16'h0080);
        bus_write(12'h800, 16'h0020);
        bus_write(12'h800, 16'h0055);
        read_check("R6 bad confirm partition 1", 12'h000, 16'h00B0);
        bus_write(12'h000, 16'h0050);
        read_check("R8 clear partition 1", 12'h000, 16'h0080);
        bus_write(12'h000, 16'h0070);
        read_check("R8 clear partition 0", 12'h000, 16'h0080);

        // R11: configuration setup consumes the next write.
        bus_write(12'h000, 16'h0060);
        bus_write(12'h000, 16'h0070);
        read_check("R11 second write consumed", 12'h010, 16'hA010);
        bus_write(12'h000, 16'h0060);
        bus_write(12'h000, 16'h0003);
        read_check("R11 back to array", 12'h011, 16'hA011);

        // R1: reset mid-run cancels a job and restores array mode.
        bus_write(12'h000, 16'h0020);
        bus_write(12'h000, 16'h00D0);
        do_reset();
        read_check("R1 array after mid reset", 12'h005, 16'hA005);
        bus_write(12'h000, 16'h0070);
        read_check("R1 job cancelled by reset", 12'h000, 16'h0080);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule